// File: doc/BRIEF.md
# Multicycle Accumulator Processor Core

A small stored-program processor. Instructions and data share one word-addressed memory of 16-bit words, reached through a synchronous single-port RAM that has one cycle of read latency. Every instruction is a 16-bit word. The top four bits hold the operation code and the low twelve bits hold an operand address. Each instruction runs as a fixed chain of register-transfer steps. The address register and the buffer register sit between the core and the memory.

The core first fetches the instruction word and advances the program counter. It then decodes the opcode. Instructions that need a memory operand load the address register from the operand field and read the word into the buffer register. The arithmetic result then lands in the accumulator. The I/O side is simple. An 8-bit input port with a valid flag is polled by the input instruction. An 8-bit output register drives a port and raises a one-cycle strobe whenever it is written. A halt instruction parks the core until reset. So does any erroneous instruction, which also raises an error flag.

Top module: `acc_core`

## Requirements
- R1: Synchronous active-high reset clears the program counter, accumulator, instruction, address and buffer registers, the output register and the halt and error flags. After reset, `mem_addr` is 0, no write or strobe is active, and the first fetch reads address 0.
- R2: Opcode 1 (load X) puts the memory word at X in the accumulator. Opcode 2 (store X) writes the accumulator to address X. An instruction word is opcode in bits 15:12 and X in bits 11:0.
- R3: Opcode 3 (add X) and opcode 4 (subtract X) set the accumulator to AC+M[X] or AC−M[X] in 16-bit two's complement, wrapping on overflow.
- R4: Opcode 5 (input) waits, with no other effect, until `in_valid` is high. It then loads `in_data` sign-extended to 16 bits into the accumulator.
- R5: Opcode 6 (output) copies the low 8 bits of the accumulator to `out_data` and pulses `out_strobe` for exactly one cycle. `out_data` changes only with that pulse.
- R6: Opcode 8 (conditional skip) tests the accumulator as chosen by bits 11:10. Code 00 tests AC<0, 01 tests AC=0 and 10 tests AC>0. When the test holds, the instruction that follows is skipped.
- R7: A conditional skip with bits 11:10 = 11 sets `error` and `halted` and performs no further memory write or output.
- R8: Opcodes 0 and 10 through 15 are illegal. They set `error` and `halted`, and both flags stay set until reset.
- R9: Opcode 7 (halt) sets `halted` with `error` low. A halted core makes no memory write and no output strobe until reset.
- R10: Opcode 9 (jump X) continues execution at address X.
- R11: `mem_we` is high for exactly one cycle per store, with `mem_addr` equal to X and `mem_wdata` equal to the accumulator. No other instruction writes memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| mem_addr | output | ADDR_W | RAM address, driven from the address register |
| mem_wdata | output | DATA_W | RAM write data, driven from the buffer register |
| mem_we | output | 1 | RAM write enable |
| mem_rdata | input | DATA_W | RAM read data, valid one cycle after the address |
| in_data | input | IO_W | Input port value |
| in_valid | input | 1 | Input port holds a value |
| out_data | output | IO_W | Output register |
| out_strobe | output | 1 | One-cycle pulse when the output register is written |
| halted | output | 1 | Core has stopped |
| error | output | 1 | Core stopped on an erroneous instruction |

## Verification
The bench builds the core with DATA_W=16, IO_W=8 and ADDR_W=8. A 256-word memory model then holds every program and operand, and each short program can run from a fresh reset. The small configuration makes several sweeps affordable:
- every pairing of eight boundary operand values (zero, ±1, the two extremes and mixed patterns) through both add and subtract;
- every skip code against negative, zero and positive accumulators;
- every illegal opcode;
- a range of input bytes on both sides of the sign bit.

// File: rtl/acc_core_pkg.sv
package acc_core_pkg;

    localparam int OP_W = 4;

    localparam logic [OP_W-1:0] OPC_LOAD  = 4'd1;
    localparam logic [OP_W-1:0] OPC_STORE = 4'd2;
    localparam logic [OP_W-1:0] OPC_ADD   = 4'd3;
    localparam logic [OP_W-1:0] OPC_SUB   = 4'd4;
    localparam logic [OP_W-1:0] OPC_IN    = 4'd5;
    localparam logic [OP_W-1:0] OPC_OUT   = 4'd6;
    localparam logic [OP_W-1:0] OPC_HALT  = 4'd7;
    localparam logic [OP_W-1:0] OPC_SKIP  = 4'd8;
    localparam logic [OP_W-1:0] OPC_JUMP  = 4'd9;

    typedef enum logic [3:0] {
        K_LOAD, K_STORE, K_ADD, K_SUB, K_IN, K_OUT,
        K_HALT, K_SKIP, K_JUMP, K_BAD
    } op_kind_e;

    typedef enum logic [3:0] {
        S_FETCH  = 4'd0,
        S_IREQ   = 4'd1,
        S_ILOAD  = 4'd2,
        S_DECODE = 4'd3,
        S_OREQ   = 4'd4,
        S_OLOAD  = 4'd5,
        S_EXEC   = 4'd6,
        S_WRITE  = 4'd7,
        S_INPUT  = 4'd8,
        S_HALT   = 4'd9
    } core_state_e;

endpackage

// File: rtl/acc_decode.sv
module acc_decode
    import acc_core_pkg::*;
(
    input  logic [OP_W-1:0] opcode,
    output op_kind_e        kind
);
    always_comb begin
        case (opcode)
            OPC_LOAD:  kind = K_LOAD;
            OPC_STORE: kind = K_STORE;
            OPC_ADD:   kind = K_ADD;
            OPC_SUB:   kind = K_SUB;
            OPC_IN:    kind = K_IN;
            OPC_OUT:   kind = K_OUT;
            OPC_HALT:  kind = K_HALT;
            OPC_SKIP:  kind = K_SKIP;
            OPC_JUMP:  kind = K_JUMP;
            default:   kind = K_BAD;
        endcase
    end
endmodule

// File: rtl/acc_alu.sv
module acc_alu #(
    parameter int W = 16
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         sub,
    output logic [W-1:0] y
);
    // Subtraction as a + ~b + 1 keeps a single adder.
    logic [W-1:0] b_eff;

    always_comb begin
        b_eff = sub ? ~b : b;
        y     = a + b_eff + {{(W-1){1'b0}}, sub};
    end
endmodule

// File: rtl/acc_skip_eval.sv
module acc_skip_eval #(
    parameter int W = 16
) (
    input  logic [W-1:0] ac,
    input  logic [1:0]   cond,
    output logic         take,
    output logic         bad
);
    logic neg, zero;

    always_comb begin
        neg  = ac[W-1];
        zero = (ac == '0);
        bad  = (cond == 2'b11);
        case (cond)
            2'b00:   take = neg;
            2'b01:   take = zero;
            2'b10:   take = !neg && !zero;
            default: take = 1'b0;
        endcase
    end
endmodule

// File: rtl/acc_core.sv
module acc_core
    import acc_core_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 12,
    parameter int IO_W   = 8
) (
    input  logic              clk,
    input  logic              rst,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              mem_we,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic [IO_W-1:0]   in_data,
    input  logic              in_valid,
    output logic [IO_W-1:0]   out_data,
    output logic              out_strobe,
    output logic              halted,
    output logic              error
);
    localparam int FIELD_W = DATA_W - OP_W;
    localparam int CND_HI  = FIELD_W - 1;
    localparam int CND_LO  = FIELD_W - 2;
    localparam int EXT_W   = DATA_W - IO_W;

    typedef struct packed {
        core_state_e       st;
        logic [ADDR_W-1:0] pc;
        logic [ADDR_W-1:0] mar;
        logic [DATA_W-1:0] ac;
        logic [DATA_W-1:0] ir;
        logic [DATA_W-1:0] mbr;
        logic [IO_W-1:0]   outr;
        logic              ostb;
        logic              halt;
        logic              err;
    } regs_t;

    regs_t r_q, r_d;

    op_kind_e          kind;
    logic [DATA_W-1:0] alu_y;
    logic              skip_take, skip_bad;
    logic [ADDR_W-1:0] opnd;
    logic [DATA_W-1:0] in_ext;

    assign opnd   = r_q.ir[ADDR_W-1:0];
    assign in_ext = {{EXT_W{in_data[IO_W-1]}}, in_data};

    acc_decode u_dec (
        .opcode (r_q.ir[DATA_W-1 -: OP_W]),
        .kind   (kind)
    );

    acc_alu #(.W(DATA_W)) u_alu (
        .a   (r_q.ac),
        .b   (r_q.mbr),
        .sub (kind == K_SUB),
        .y   (alu_y)
    );

    acc_skip_eval #(.W(DATA_W)) u_skp (
        .ac   (r_q.ac),
        .cond (r_q.ir[CND_HI:CND_LO]),
        .take (skip_take),
        .bad  (skip_bad)
    );

    always_comb begin
        r_d      = r_q;
        r_d.ostb = 1'b0;
        case (r_q.st)
            S_FETCH: begin
                r_d.mar = r_q.pc;
                r_d.st  = S_IREQ;
            end
            S_IREQ: begin
                r_d.st = S_ILOAD;
            end
            S_ILOAD: begin
                r_d.ir = mem_rdata;
                r_d.pc = r_q.pc + 1'b1;
                r_d.st = S_DECODE;
            end
            S_DECODE: begin
                case (kind)
                    K_LOAD, K_ADD, K_SUB: begin
                        r_d.mar = opnd;
                        r_d.st  = S_OREQ;
                    end
                    K_STORE: begin
                        r_d.mar = opnd;
                        r_d.mbr = r_q.ac;
                        r_d.st  = S_WRITE;
                    end
                    K_IN: begin
                        r_d.st = S_INPUT;
                    end
                    K_OUT: begin
                        r_d.outr = r_q.ac[IO_W-1:0];
                        r_d.ostb = 1'b1;
                        r_d.st   = S_FETCH;
                    end
                    K_HALT: begin
                        r_d.halt = 1'b1;
                        r_d.st   = S_HALT;
                    end
                    K_SKIP: begin
                        if (skip_bad) begin
                            r_d.err  = 1'b1;
                            r_d.halt = 1'b1;
                            r_d.st   = S_HALT;
                        end else begin
                            if (skip_take) begin
                                r_d.pc = r_q.pc + 1'b1;
                            end
                            r_d.st = S_FETCH;
                        end
                    end
                    K_JUMP: begin
                        r_d.pc = opnd;
                        r_d.st = S_FETCH;
                    end
                    default: begin
                        r_d.err  = 1'b1;
                        r_d.halt = 1'b1;
                        r_d.st   = S_HALT;
                    end
                endcase
            end
            S_OREQ: begin
                r_d.st = S_OLOAD;
            end
            S_OLOAD: begin
                r_d.mbr = mem_rdata;
                r_d.st  = S_EXEC;
            end
            S_EXEC: begin
                r_d.ac = (kind == K_LOAD) ? r_q.mbr : alu_y;
                r_d.st = S_FETCH;
            end
            S_WRITE: begin
                r_d.st = S_FETCH;
            end
            S_INPUT: begin
                if (in_valid) begin
                    r_d.ac = in_ext;
                    r_d.st = S_FETCH;
                end
            end
            S_HALT: begin
                r_d.st = S_HALT;
            end
            default: begin
                r_d.st = S_FETCH;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign mem_addr   = r_q.mar;
    assign mem_wdata  = r_q.mbr;
    assign mem_we     = (r_q.st == S_WRITE);
    assign out_data   = r_q.outr;
    assign out_strobe = r_q.ostb;
    assign halted     = r_q.halt;
    assign error      = r_q.err;

endmodule

// File: rtl/acc_core_chk.sv
module acc_core_chk #(
    parameter int ADDR_W = 12,
    parameter int IO_W   = 8
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_we,
    input logic [IO_W-1:0]   out_data,
    input logic              out_strobe,
    input logic              halted,
    input logic              error
);
    logic seen;

    always_ff @(posedge clk) begin
        if (rst) seen <= 1'b0;
        else     seen <= 1'b1;
    end

    p_reset_state_r1: assert property (@(posedge clk) disable iff (rst)
        !seen |-> (mem_addr == '0 && !mem_we && !out_strobe && !halted && !error));

    p_strobe_single_r5: assert property (@(posedge clk) disable iff (rst)
        out_strobe |=> !out_strobe);

    p_out_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (seen && !out_strobe) |-> $stable(out_data));

    p_err_halts_r7: assert property (@(posedge clk) disable iff (rst)
        error |-> halted);

    p_err_sticky_r8: assert property (@(posedge clk) disable iff (rst)
        error |=> error);

    p_halt_sticky_r9: assert property (@(posedge clk) disable iff (rst)
        halted |=> halted);

    p_halt_quiet_r9: assert property (@(posedge clk) disable iff (rst)
        halted |-> (!mem_we && !out_strobe));

    p_we_single_r11: assert property (@(posedge clk) disable iff (rst)
        mem_we |=> !mem_we);

endmodule

bind acc_core acc_core_chk #(.ADDR_W(ADDR_W), .IO_W(IO_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .mem_addr   (mem_addr),
    .mem_we     (mem_we),
    .out_data   (out_data),
    .out_strobe (out_strobe),
    .halted     (halted),
    .error      (error)
);

// File: tb/acc_core_bench.sv
`timescale 1ns/1ps
module acc_core_bench;
    localparam int DW = 16;
    localparam int AW = 8;
    localparam int IW = 8;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_wdata;
    logic          mem_we;
    logic [DW-1:0] mem_rdata;
    logic [IW-1:0] in_data = '0;
    logic          in_valid = 1'b0;
    logic [IW-1:0] out_data;
    logic          out_strobe;
    logic          halted;
    logic          error;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    logic [DW-1:0] mem [DEPTH];
    int            wr_cnt;
    int            stb_cnt;
    logic [AW-1:0] last_wr_addr;
    logic [IW-1:0] out_log [4];

    always #2 clk = ~clk;

    acc_core #(.DATA_W(DW), .ADDR_W(AW), .IO_W(IW)) u_acc_core (
        .clk        (clk),
        .rst        (rst),
        .mem_addr   (mem_addr),
        .mem_wdata  (mem_wdata),
        .mem_we     (mem_we),
        .mem_rdata  (mem_rdata),
        .in_data    (in_data),
        .in_valid   (in_valid),
        .out_data   (out_data),
        .out_strobe (out_strobe),
        .halted     (halted),
        .error      (error)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        mem_rdata <= mem[mem_addr];
        if (mem_we && !rst) begin
            mem[mem_addr] <= mem_wdata;
            wr_cnt        <= wr_cnt + 1;
            last_wr_addr  <= mem_addr;
        end
        if (out_strobe && !rst) begin
            if (stb_cnt < 4) out_log[stb_cnt] <= out_data;
            stb_cnt <= stb_cnt + 1;
        end
        if (rst) begin
            wr_cnt  <= 0;
            stb_cnt <= 0;
        end
    end

    function automatic logic [DW-1:0] ins(input logic [3:0] op, input logic [11:0] x);
        return {op, x};
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic clear_mem();
        for (int i = 0; i < DEPTH; i++) mem[i] = '0;
    endtask

    task automatic start_prog();
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic wait_halt(input int maxc, input string req);
        int n = 0;
        while (!halted && n < maxc) begin
            @(negedge clk);
            n++;
        end
        chk(halted, req, {31'd0, halted}, 32'd1);
    endtask

    initial begin : wdog
        wait (cycles > 150000);
        errors++;
        $display("FAIL watchdog actual=%0d expected=<150000", cycles);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : main
        logic [DW-1:0] vals [8];
        logic [DW-1:0] svals [5];
        logic [IW-1:0] ivals [5];
        logic [DW-1:0] exp;
        logic [3:0]    bad_ops [7];

        vals[0] = 16'h0000; vals[1] = 16'h0001; vals[2] = 16'hFFFF; vals[3] = 16'h7FFF;
        vals[4] = 16'h8000; vals[5] = 16'h1234; vals[6] = 16'hFEDC; vals[7] = 16'h0005;
        svals[0] = 16'h8000; svals[1] = 16'hFFFF; svals[2] = 16'h0000;
        svals[3] = 16'h0001; svals[4] = 16'h7FFF;
        ivals[0] = 8'h00; ivals[1] = 8'h7F; ivals[2] = 8'h80; ivals[3] = 8'h9C; ivals[4] = 8'hFF;
        bad_ops[0] = 4'd0;  bad_ops[1] = 4'd10; bad_ops[2] = 4'd11; bad_ops[3] = 4'd12;
        bad_ops[4] = 4'd13; bad_ops[5] = 4'd14; bad_ops[6] = 4'd15;

        // R1: state during and right after reset
        clear_mem();
        repeat (3) @(negedge clk);
        chk(!halted && !error && !mem_we && !out_strobe, "R1 flags", {halted, error, mem_we, out_strobe}, 0);
        chk(mem_addr == '0, "R1 addr", mem_addr, 0);
        rst = 1'b0;
        @(negedge clk);
        chk(mem_addr == '0 && !mem_we, "R1 first fetch address", mem_addr, 0);

        // R2 R3 R11: load, add or subtract, store sweep
        for (int s = 0; s < 2; s++) begin
            for (int i = 0; i < 8; i++) begin
                for (int j = 0; j < 8; j++) begin
                    clear_mem();
                    mem[0] = ins(4'd1, 12'h040);
                    mem[1] = ins(s ? 4'd4 : 4'd3, 12'h041);
                    mem[2] = ins(4'd2, 12'h042);
                    mem[3] = ins(4'd7, 12'h000);
                    mem[8'h40] = vals[i];
                    mem[8'h41] = vals[j];
                    start_prog();
                    wait_halt(200, "R9 halt reached");
                    exp = s ? vals[i] - vals[j] : vals[i] + vals[j];
                    chk(mem[8'h42] == exp, s ? "R3 subtract" : "R3 add", mem[8'h42], exp);
                    chk(mem[8'h40] == vals[i], "R2 load source intact", mem[8'h40], vals[i]);
                    chk(wr_cnt == 1 && last_wr_addr == 8'h42, "R11 single store", wr_cnt, 1);
                    chk(!error, "R9 no error on halt", error, 0);
                end
            end
        end

        // R2: plain load/store copy
        clear_mem();
        mem[0] = ins(4'd1, 12'h050);
        mem[1] = ins(4'd2, 12'h051);
        mem[2] = ins(4'd7, 12'h000);
        mem[8'h50] = 16'hC3A5;
        start_prog();
        wait_halt(200, "R2 halt");
        chk(mem[8'h51] == 16'hC3A5, "R2 copy", mem[8'h51], 16'hC3A5);

        // R6: skip codes 00/01/10 against sign classes
        for (int c = 0; c < 3; c++) begin
            for (int v = 0; v < 5; v++) begin
                bit take;
                clear_mem();
                mem[0] = ins(4'd1, 12'h040);
                mem[1] = ins(4'd8, {c[1:0], 10'd0});
                mem[2] = ins(4'd1, 12'h041);
                mem[3] = ins(4'd2, 12'h042);
                mem[4] = ins(4'd7, 12'h000);
                mem[8'h40] = svals[v];
                mem[8'h41] = 16'hAAAA;
                start_prog();
                wait_halt(200, "R6 halt");
                case (c)
                    0:       take = svals[v][15];
                    1:       take = (svals[v] == 16'h0);
                    default: take = !svals[v][15] && svals[v] != 16'h0;
                endcase
                exp = take ? svals[v] : 16'hAAAA;
                chk(mem[8'h42] == exp && !error, "R6 skip", mem[8'h42], exp);
            end
        end

        // R7: skip code 11
        clear_mem();
        mem[0] = ins(4'd8, 12'hC00);
        mem[1] = ins(4'd2, 12'h042);
        mem[2] = ins(4'd7, 12'h000);
        start_prog();
        wait_halt(200, "R7 halt");
        repeat (20) @(negedge clk);
        chk(error && halted, "R7 error flag", {error, halted}, 2'b11);
        chk(wr_cnt == 0, "R7 no write", wr_cnt, 0);

        // R8: illegal opcodes
        for (int k = 0; k < 7; k++) begin
            clear_mem();
            mem[0] = ins(bad_ops[k], 12'h042);
            mem[1] = ins(4'd2, 12'h042);
            mem[2] = ins(4'd7, 12'h000);
            start_prog();
            wait_halt(200, "R8 halt");
            repeat (10) @(negedge clk);
            chk(error && halted && wr_cnt == 0, "R8 illegal opcode", {bad_ops[k], error, halted}, {bad_ops[k], 2'b11});
        end

        // R9: halt stops execution
        clear_mem();
        mem[0] = ins(4'd7, 12'h000);
        mem[1] = ins(4'd6, 12'h000);
        mem[2] = ins(4'd2, 12'h042);
        start_prog();
        wait_halt(200, "R9 halt");
        repeat (30) @(negedge clk);
        chk(halted && !error && wr_cnt == 0 && stb_cnt == 0, "R9 quiet halt", {wr_cnt[7:0], stb_cnt[7:0]}, 0);

        // R10: jump
        clear_mem();
        mem[0] = ins(4'd9, 12'h005);
        mem[1] = ins(4'd1, 12'h041);
        mem[2] = ins(4'd2, 12'h042);
        mem[3] = ins(4'd7, 12'h000);
        mem[5] = ins(4'd1, 12'h040);
        mem[6] = ins(4'd2, 12'h043);
        mem[7] = ins(4'd7, 12'h000);
        mem[8'h40] = 16'h1357;
        mem[8'h41] = 16'hAAAA;
        start_prog();
        wait_halt(200, "R10 halt");
        chk(mem[8'h43] == 16'h1357 && mem[8'h42] == 16'h0, "R10 jump target", mem[8'h43], 16'h1357);
        chk(wr_cnt == 1, "R11 jump path writes", wr_cnt, 1);

        // R4 R5: input waits, sign-extends; output low byte with strobe
        for (int v = 0; v < 5; v++) begin
            clear_mem();
            in_valid = 1'b0;
            in_data  = ivals[v];
            mem[0] = ins(4'd5, 12'h000);
            mem[1] = ins(4'd2, 12'h042);
            mem[2] = ins(4'd6, 12'h000);
            mem[3] = ins(4'd1, 12'h040);
            mem[4] = ins(4'd6, 12'h000);
            mem[5] = ins(4'd7, 12'h000);
            mem[8'h40] = 16'h1234;
            start_prog();
            repeat (30) @(negedge clk);
            chk(!halted && wr_cnt == 0 && stb_cnt == 0, "R4 waits for valid", wr_cnt, 0);
            in_valid = 1'b1;
            wait_halt(200, "R4 halt");
            in_valid = 1'b0;
            exp = {{8{ivals[v][7]}}, ivals[v]};
            chk(mem[8'h42] == exp, "R4 sign extension", mem[8'h42], exp);
            chk(stb_cnt == 2, "R5 strobe count", stb_cnt, 2);
            chk(out_log[0] == ivals[v], "R5 first output", out_log[0], ivals[v]);
            chk(out_log[1] == 8'h34 && out_data == 8'h34, "R5 low byte", out_data, 8'h34);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule